// File: doc/BRIEF.md
# Three-Operand Adder with Carry-or-Borrow Intermediate Form

This block adds three unsigned N-bit operands in a single combinational pass. A row of one-bit cells turns each bit position into a redundant digit that is carried on two wires: a parity bit `u` and an inverted-majority bit `r`. The cell works as if a carry of one arrives at every position and a carry of one leaves it. Each digit therefore has the value `a + b + c - 1`, which lies between -1 and +2, instead of the 0 to 3 range of a carry-save digit.

A conversion stage then collapses the redundant vector into an ordinary binary sum. The two values it adds are the parity vector, and the complemented `r` bits placed one position higher. The stage is a ripple chain of cells. Each cell forms its output from the first operand, a diagonal term made from adjacent bits of the second operand, and a travelling `z` signal. The result is N+2 bits wide, so it can hold the largest possible total. The block has no clock or state: `sum` follows the operands within the same cycle.

Top module: `scb_three_operand_adder`

## Requirements
- R1: At each bit position the digit is formed as `u = a^b^c` and `r = NOT majority(a,b,c)`. It satisfies `u - 2*r + 1 = a+b+c-1`. When the operands are non-zero at a single position n only, `sum` equals `(a_n+b_n+c_n)*2^n`.
- R2: For any operands, `sum` equals `a + b + c` computed exactly on N+2 bits.
- R3: With all three operands at all ones, `sum` equals `3*(2^N-1)` and does not overflow. For N=8 this is 765.
- R4: With all three operands zero, `sum` is zero, even though every digit holds its -1 offset.
- R5: A carry that must travel across the full operand width reaches the top bit. For N=8, `a=8'hFF`, `b=1`, `c=0` gives 256, and `a=b=8'hFF`, `c=1` gives 511.
- R6: `sum` does not depend on which port carries which operand: all six permutations of a triple give the same result.
- R7: The block is combinational. `sum` reflects new operands within the same clock period in which they are applied, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First addend |
| b | input | N | Second addend |
| c | input | N | Third addend |
| sum | output | N+2 | Binary total of the three addends |

## Verification
Forming the digits and resolving the z chain across the full width both have to settle within one and the same evaluation. A wrong digit sign or a broken link in the chain would therefore show up only when a long propagation also depends on offset-corrected digits. The bench provokes this with all-ones operands combined with a small third operand. It also sweeps every input combination for the four-bit variant, so that every offset pattern meets every chain length. Each result is judged against the integer sum that the scoreboard queues for that cycle, and it is sampled half a period after the operands change.

// File: rtl/scb_pkg.sv
`timescale 1ns/1ps
package scb_pkg;
  // One redundant digit: parity part and inverted-majority (negative weight) part
  typedef struct packed {
    logic u;
    logic r;
  } scb_digit_t;
endpackage

// File: rtl/scb_digit_cell.sv
`timescale 1ns/1ps
module scb_digit_cell
  import scb_pkg::*;
(
  input  logic       op_a,
  input  logic       op_b,
  input  logic       op_c,
  output scb_digit_t dig
);
  always_comb begin
    dig.u = op_a ^ op_b ^ op_c;
    // AND/XOR form of the complemented majority
    dig.r = 1'b1 ^ (op_a & op_b) ^ (op_b & op_c) ^ (op_c & op_a);
  end

  // R1: digit value with assumed in/out carries matches the bit count minus one
  always_comb begin
    assert_digit_value_R1: assert ((int'(dig.u) - 2 * int'(dig.r) + 1) ==
                                   (int'(op_a) + int'(op_b) + int'(op_c) - 1))
      else $error("digit value mismatch");
    // R1: r may only be set when at most one input bit is high
    assert_borrow_bound_R1: assert (!dig.r || ((int'(op_a) + int'(op_b) + int'(op_c)) <= 1))
      else $error("r set with two or more inputs high");
  end
endmodule

// File: rtl/scb_ripple_cell.sv
`timescale 1ns/1ps
module scb_ripple_cell (
  input  logic x_bit,
  input  logic q_bit,
  input  logic p_bit,
  input  logic z_in,
  output logic s_bit,
  output logic z_out
);
  logic t_bit;
  always_comb begin
    t_bit = q_bit ^ z_in;
    s_bit = x_bit ^ t_bit;
    z_out = p_bit & t_bit;
  end
endmodule

// File: rtl/scb_convert.sv
`timescale 1ns/1ps
module scb_convert #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] opx,
  input  logic [W-1:0] opy,
  output logic [W-1:0] res
);
  logic [W-1:0] p_vec;
  logic [W-1:0] q_vec;
  logic [W-1:0] z_vec;

  always_comb begin
    p_vec = opx ^ opy;
    // diagonal term: current bit of opy against the one below (no carry input)
    q_vec = opy ^ {opy[W-2:0], 1'b0};
    z_vec[0] = 1'b0;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < W - 1) begin : g_link
      scb_ripple_cell u_cell (
        .x_bit (opx[i]),
        .q_bit (q_vec[i]),
        .p_bit (p_vec[i]),
        .z_in  (z_vec[i]),
        .s_bit (res[i]),
        .z_out (z_vec[i+1])
      );
    end else begin : g_last
      // top position has no successor, so the z output is not formed
      assign res[i] = opx[i] ^ q_vec[i] ^ z_vec[i];
    end
  end

  // R2: the z chain delivers the binary sum of its two operands
  always_comb begin
    assert_chain_sum_R2: assert (res == W'(opx + opy))
      else $error("conversion chain result differs from operand sum");
  end
endmodule

// File: rtl/scb_three_operand_adder.sv
`timescale 1ns/1ps
module scb_three_operand_adder
  import scb_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] c,
  output logic [N+1:0] sum
);
  localparam int unsigned W = N + 2;
  localparam logic [W-1:0] MAX_SUM = W'(3) * ((W'(1) << N) - W'(1));

  scb_digit_t [N-1:0] digs;
  logic [N-1:0]       u_vec;
  logic [N-1:0]       rn_vec;
  logic [W-1:0]       par_op;
  logic [W-1:0]       maj_op;

  for (genvar n = 0; n < N; n++) begin : g_digit
    scb_digit_cell u_dig (
      .op_a (a[n]),
      .op_b (b[n]),
      .op_c (c[n]),
      .dig  (digs[n])
    );
    assign u_vec[n]  = digs[n].u;
    assign rn_vec[n] = ~digs[n].r;
  end

  always_comb begin
    par_op = {2'b00, u_vec};
    // complemented r carries weight 2^(n+1); this absorbs the assumed carries
    maj_op = {1'b0, rn_vec, 1'b0};
  end

  scb_convert #(.W(W)) u_conv (
    .opx (par_op),
    .opy (maj_op),
    .res (sum)
  );

  always_comb begin
    assert_sum_exact_R2: assert (sum == (W'(a) + W'(b) + W'(c)))
      else $error("sum differs from a+b+c");
    assert_no_overflow_R3: assert (sum <= MAX_SUM)
      else $error("sum exceeds largest reachable total");
    assert_zero_in_zero_out_R4: assert (!((a == '0) && (b == '0) && (c == '0)) || (sum == '0))
      else $error("zero operands gave non-zero sum");
  end
endmodule

// File: tb/scb_three_operand_adder_tb_top.sv
`timescale 1ns/1ps
module scb_three_operand_adder_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [7:0] a8, b8, c8;
  logic [9:0] s8;
  logic [3:0] a4, b4, c4;
  logic [5:0] s4;

  scb_three_operand_adder #(.N(8)) dut_i  (.a(a8), .b(b8), .c(c8), .sum(s8));
  scb_three_operand_adder #(.N(4)) dut4_i (.a(a4), .b(b4), .c(c4), .sum(s4));

  typedef struct {
    logic [9:0] exp;
    string      req;
    logic [7:0] xa, xb, xc;
  } item_t;

  item_t q8[$];
  item_t q4[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic drive8(input logic [7:0] xa, xb, xc, input logic [9:0] exp, input string req);
    item_t it;
    @(posedge clk);
    #1;
    a8 = xa; b8 = xb; c8 = xc;
    it.exp = exp; it.req = req; it.xa = xa; it.xb = xb; it.xc = xc;
    q8.push_back(it);
  endtask

  task automatic drive4(input logic [3:0] xa, xb, xc, input logic [9:0] exp, input string req);
    item_t it;
    @(posedge clk);
    #1;
    a4 = xa; b4 = xb; c4 = xc;
    it.exp = exp; it.req = req; it.xa = 8'(xa); it.xb = 8'(xb); it.xc = 8'(xc);
    q4.push_back(it);
  endtask

  // Monitor: samples half a period after the operands were applied (R7)
  always @(negedge clk) begin
    if (q8.size() > 0) begin
      item_t it;
      it = q8.pop_front();
      checks++;
      if (s8 !== it.exp) begin
        errors++;
        $display("FAIL %s N=8 a=%h b=%h c=%h actual=%0d expected=%0d",
                 it.req, it.xa, it.xb, it.xc, s8, it.exp);
      end
    end
    if (q4.size() > 0) begin
      item_t it;
      it = q4.pop_front();
      checks++;
      if (10'(s4) !== it.exp) begin
        errors++;
        $display("FAIL %s N=4 a=%h b=%h c=%h actual=%0d expected=%0d",
                 it.req, it.xa, it.xb, it.xc, s4, it.exp);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    a8 = '0; b8 = '0; c8 = '0;
    a4 = '0; b4 = '0; c4 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    drive8(8'h00, 8'h00, 8'h00, 10'd0, "R4");
    drive8(8'hFF, 8'hFF, 8'hFF, 10'd765, "R3");
    drive8(8'hFF, 8'h01, 8'h00, 10'd256, "R5");
    drive8(8'hFF, 8'hFF, 8'h01, 10'd511, "R5");
    drive8(8'h80, 8'h80, 8'h80, 10'd384, "R3");

    // R1: one active position at a time, all bit combinations there
    for (int n = 0; n < 8; n++) begin
      for (int k = 0; k < 8; k++) begin
        logic ba, bb, bc;
        ba = k[0]; bb = k[1]; bc = k[2];
        drive8(8'(ba) << n, 8'(bb) << n, 8'(bc) << n,
               (10'(ba) + 10'(bb) + 10'(bc)) << n, "R1");
      end
    end

    // R6: every permutation of a few triples gives the same total
    for (int t = 0; t < 8; t++) begin
      logic [7:0] x, y, z;
      logic [9:0] e;
      x = 8'($urandom); y = 8'($urandom); z = 8'($urandom);
      e = 10'(x) + 10'(y) + 10'(z);
      drive8(x, y, z, e, "R6");
      drive8(x, z, y, e, "R6");
      drive8(y, x, z, e, "R6");
      drive8(y, z, x, e, "R6");
      drive8(z, x, y, e, "R6");
      drive8(z, y, x, e, "R6");
    end

    // R2: every input combination of the four-bit variant
    for (int i = 0; i < 4096; i++) begin
      logic [3:0] x, y, z;
      x = 4'(i); y = 4'(i >> 4); z = 4'(i >> 8);
      drive4(x, y, z, 10'(x) + 10'(y) + 10'(z), "R2");
    end

    // R2/R7: random operands, a new triple in every cycle
    for (int i = 0; i < 10000; i++) begin
      logic [7:0] x, y, z;
      x = 8'($urandom); y = 8'($urandom); z = 8'($urandom);
      drive8(x, y, z, 10'(x) + 10'(y) + 10'(z), "R2");
    end

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule